// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-mapped master for the extended (Clause 45) MDIO management protocol. Software first loads a 16-bit register address into the address register. It then writes a command word into the management register. The command word carries the operation, the port address, the device address and, for writes, the data. A single accepted command expands into two serial transactions. The first is an address frame that delivers the stored register address to the selected port and device. The second is a data frame to the same port and device, which either writes the command data or reads 16 bits back.

Software polls the busy flag before it issues a command and again before it collects read data. Busy stays high without a gap from the cycle after the command is accepted until the data frame's last bit period has ended. When a read finishes, its result appears in the low half of the management register and the read-valid flag is set. MDC is a free-running clock made by dividing the system clock. The master changes MDIO on falling MDC and samples the returned data on rising MDC.

Top module: `mdio45_master`

## Requirements
- R1: The address register sits at byte offset 0x8. It stores only bits 15:0 of a write and reads back with bits 31:16 at zero.
- R2: A management-register write (offset 0x0) is accepted when the block is idle and the operation field (bits 28:26) holds 5 (write) or 7 (read). The write also supplies the port address in bits 20:16, the device address in bits 25:21 and the data in bits 15:0. Busy (bit 30) reads 1 from the next cycle and returns to 0 only after both frames have been sent.
- R3: The first frame consists of at least 32 ones, start 00, opcode 00, the 5-bit port, the 5-bit device, turnaround 10 and the 16-bit stored register address. All fields are sent MSB first.
- R4: For a write command, the second frame carries opcode 01, the same port and device, turnaround 10 and command bits 15:0.
- R5: For a read command, the second frame carries opcode 11. The master releases MDIO from the turnaround onward and captures 16 bits, MSB first, on rising MDC. When the read ends, those bits appear in management bits 15:0 and read-valid (bit 29) is 1.
- R6: Every accepted command clears read-valid from the next cycle.
- R7: A management write whose operation field is neither 5 nor 7 is ignored. Busy stays 0 and no frame is sent.
- R8: A management write made while busy is dropped. The frames in progress and the port field that reads back are unchanged.
- R9: MDC has a period of 2*DIV_HALF system clocks. MDIO output-enable is 0 while no frame is active.
- R10: After reset, both registers read 0 and MDIO output-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (0x0 management, 0x8 address) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The hardest situation to reach is a read whose second frame really turns the bus around. That requires a device which recognises the address frame, latches the register address, and then drives the turnaround low bit and 16 data bits in step with MDC. The bench provides a behavioural peripheral model that decodes frames bit by bit on rising MDC and drives its reply on falling MDC. Its reply is derived from the latched address, port and device, so any error in capture timing or bit order changes the value that reads back. Two other cases need precise timing: a second command landing while the first is still busy, and a read-valid flag that must be cleared by the next command. Both are driven by back-to-back register writes issued a cycle apart.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;
  localparam int FRAME_W = 64;
  localparam int DATA_W  = 16;
  localparam int PRE_W   = 32;
  localparam int IDX_W   = $clog2(FRAME_W);

  localparam logic [2:0] CMD_WR = 3'd5;
  localparam logic [2:0] CMD_RD = 3'd7;

  localparam logic [1:0] FOP_ADDR = 2'b00;
  localparam logic [1:0] FOP_WR   = 2'b01;
  localparam logic [1:0] FOP_RD   = 2'b11;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ADDR, SEQ_DATA} seq_e;

  function automatic logic [FRAME_W-1:0] build_frame(input logic [1:0] fop,
                                                     input logic [4:0] prt,
                                                     input logic [4:0] dev,
                                                     input logic [DATA_W-1:0] fld);
    return {{PRE_W{1'b1}}, 2'b00, fop, prt, dev, 2'b10, fld};
  endfunction
endpackage

// File: rtl/mdio45_mdc_gen.sv
module mdio45_mdc_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] TERM = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = (cnt == TERM);
  assign rise_tick = wrap & ~mdc;
  assign fall_tick = wrap & mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9
  mdc_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> (cnt == '0));
endmodule

// File: rtl/mdio45_frame_eng.sv
module mdio45_frame_eng
  import mdio45_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               is_read,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               mdio_o,
  output logic               mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FRAME_W - DATA_W - 2);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(FRAME_W - DATA_W);
  localparam logic [IDX_W-1:0] PRE_END  = IDX_W'(PRE_W);

  logic               pend, act, rd_q;
  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] sh;
  logic [DATA_W-1:0]  cap;

  assign busy    = pend | act;
  assign mdio_o  = sh[FRAME_W-1];
  assign mdio_oe = act & ~(rd_q & (idx >= TA_IDX));
  assign rd_data = cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      act  <= 1'b0;
      rd_q <= 1'b0;
      idx  <= '0;
      sh   <= '0;
      cap  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !pend && !act) begin
        pend <= 1'b1;
        sh   <= frame;
        rd_q <= is_read;
      end else if (pend && fall_tick) begin
        pend <= 1'b0;
        act  <= 1'b1;
        idx  <= '0;
      end else if (act && rise_tick) begin
        if (rd_q && idx >= DAT_IDX) cap <= {cap[DATA_W-2:0], mdio_i};
      end else if (act && fall_tick) begin
        if (idx == LAST_IDX) begin
          act  <= 1'b0;
          done <= 1'b1;
        end else begin
          sh  <= {sh[FRAME_W-2:0], 1'b0};
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R3
  preamble_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && idx < PRE_END) |-> (mdio_oe && mdio_o));
endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
  import mdio45_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam logic [3:0] OFS_MGMT = 4'h0;
  localparam logic [3:0] OFS_REGA = 4'h8;

  seq_e               state;
  logic [DATA_W-1:0]  rega_q, data_q;
  logic [4:0]         prt_q, dev_q;
  logic [2:0]         opc_q;
  logic               valid_q;
  logic               eng_start, eng_rd, eng_busy, eng_done;
  logic [FRAME_W-1:0] eng_frame;
  logic [DATA_W-1:0]  eng_rdata;
  logic               rise_tick, fall_tick;
  logic               busy, wr_mgmt, op_ok, accept;
  logic [2:0]         op_in;
  logic               unused_bits;

  assign unused_bits = ^{reg_wdata[31:29], eng_busy};
  assign busy    = (state != SEQ_IDLE);
  assign wr_mgmt = reg_wr && (reg_addr == OFS_MGMT);
  assign op_in   = reg_wdata[28:26];
  assign op_ok   = (op_in == CMD_WR) || (op_in == CMD_RD);
  assign accept  = wr_mgmt && !busy && op_ok;

  mdio45_mdc_gen #(.DIV_HALF(DIV_HALF)) mdc_i (
    .clk(clk), .rst_n(rst_n), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio45_frame_eng eng_i (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .start(eng_start), .frame(eng_frame), .is_read(eng_rd), .mdio_i(mdio_i),
    .busy(eng_busy), .done(eng_done), .rd_data(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      rega_q    <= '0;
      data_q    <= '0;
      prt_q     <= '0;
      dev_q     <= '0;
      opc_q     <= '0;
      valid_q   <= 1'b0;
      eng_start <= 1'b0;
      eng_rd    <= 1'b0;
      eng_frame <= '0;
    end else begin
      eng_start <= 1'b0;
      if (reg_wr && reg_addr == OFS_REGA) rega_q <= reg_wdata[DATA_W-1:0];
      unique case (state)
        SEQ_IDLE: if (accept) begin
          prt_q     <= reg_wdata[20:16];
          dev_q     <= reg_wdata[25:21];
          opc_q     <= op_in;
          data_q    <= reg_wdata[DATA_W-1:0];
          valid_q   <= 1'b0;
          eng_start <= 1'b1;
          eng_rd    <= 1'b0;
          eng_frame <= build_frame(FOP_ADDR, reg_wdata[20:16], reg_wdata[25:21], rega_q);
          state     <= SEQ_ADDR;
        end
        SEQ_ADDR: if (eng_done) begin
          eng_start <= 1'b1;
          eng_rd    <= (opc_q == CMD_RD);
          eng_frame <= (opc_q == CMD_RD) ? build_frame(FOP_RD, prt_q, dev_q, '0)
                                         : build_frame(FOP_WR, prt_q, dev_q, data_q);
          state     <= SEQ_DATA;
        end
        SEQ_DATA: if (eng_done) begin
          state <= SEQ_IDLE;
          if (eng_rd) begin
            data_q  <= eng_rdata;
            valid_q <= 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_MGMT: reg_rdata = {1'b0, busy, valid_q, opc_q, dev_q, prt_q, data_q};
      OFS_REGA: reg_rdata = {16'h0000, rega_q};
      default:  reg_rdata = '0;
    endcase
  end

  // R2
  cmd_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mgmt && !busy && op_ok) |=> busy);
  // R7
  bad_op_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mgmt && !busy && !op_ok) |=> !busy);
  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_mgmt) |=> ($stable(prt_q) && $stable(dev_q)));
  // R6
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !valid_q);
endmodule

// File: tb/mdio45_master_tb.sv
module mdio45_master_tb_top;
  localparam int DIV_HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_i, mdio_o, mdio_oe;
  logic        slv_oe = 1'b0, slv_bit = 1'b1;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  assign mdio_i = slv_oe ? slv_bit : 1'b1;

  mdio45_master #(.DIV_HALF(DIV_HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [4:0]  prt;
    logic [4:0]  dev;
    logic [15:0] ra;
    logic [15:0] wd;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd5, 5'd1,  5'd1,  16'h0000, 16'hBEEF},
    '{3'd7, 5'd1,  5'd1,  16'h0000, 16'h0000},
    '{3'd5, 5'd31, 5'd31, 16'hFFFF, 16'h0000},
    '{3'd7, 5'd31, 5'd31, 16'hFFFF, 16'h0000},
    '{3'd5, 5'd0,  5'd30, 16'h1234, 16'hA5A5},
    '{3'd7, 5'd16, 5'd3,  16'h8001, 16'h0000}
  };

  function automatic logic [15:0] mdl(input logic [15:0] a, input logic [4:0] p, input logic [4:0] d);
    return a ^ 16'h5A3C ^ {p, d, 6'h15};
  endfunction

  function automatic logic [31:0] mk(input logic [2:0] op, input logic [4:0] p, input logic [4:0] d, input logic [15:0] v);
    return {3'b000, op, d, p, v};
  endfunction

  // peripheral model: decodes frames on rising MDC, answers on falling MDC
  int          ones = 0, pos = -1, nf = 0;
  logic [13:0] hdr;
  logic [1:0]  ta;
  logic [15:0] dat, rdval, slv_addr = '0;
  logic        rd_fr = 1'b0;
  logic [1:0]  f_op [64];
  logic [1:0]  f_st [64];
  logic [1:0]  f_ta [64];
  logic [4:0]  f_prt [64];
  logic [4:0]  f_dev [64];
  logic [15:0] f_dat [64];
  int          f_pre [64];

  always @(posedge mdc) begin
    logic b;
    b = mdio_oe ? mdio_o : (slv_oe ? slv_bit : 1'b1);
    if (pos < 0) begin
      if (b) ones++;
      else begin
        if (ones >= 32) begin pos = 1; hdr = '0; f_pre[nf % 64] = ones; end
        ones = 0;
      end
    end else begin
      if (pos < 14) hdr = {hdr[12:0], b};
      else if (pos < 16) ta = {ta[0], b};
      else dat = {dat[14:0], b};
      if (pos == 13) begin
        rd_fr = (hdr[11:10] == 2'b11);
        if (rd_fr) rdval = mdl(slv_addr, hdr[9:5], hdr[4:0]);
      end
      if (pos == 31) begin
        f_st[nf % 64] = hdr[13:12]; f_op[nf % 64] = hdr[11:10];
        f_prt[nf % 64] = hdr[9:5];  f_dev[nf % 64] = hdr[4:0];
        f_ta[nf % 64] = ta;          f_dat[nf % 64] = dat;
        if (hdr[11:10] == 2'b00) slv_addr = dat;
        nf++; pos = -1; ones = 0; rd_fr = 1'b0;
      end else pos++;
    end
  end

  always @(negedge mdc) begin
    if (pos >= 0 && rd_fr && pos == 15) begin slv_oe = 1'b1; slv_bit = 1'b0; end
    else if (pos >= 16 && rd_fr) begin slv_oe = 1'b1; slv_bit = rdval[31 - pos]; end
    else slv_oe = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] d);
    for (int i = 0; i < 5000; i++) begin
      rd(4'h0, d);
      if (!d[30]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R2 act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n0;
    realtime t0, t1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(4'h0, d); chk("R10 mgmt", d, 32'h0);
    rd(4'h8, d); chk("R10 rega", d, 32'h0);
    chk("R10 oe", {31'b0, mdio_oe}, 32'h0);
    // R1 address register width
    wr(4'h8, 32'hFFFF_1234);
    rd(4'h8, d); chk("R1 rega", d, 32'h0000_1234);
    // R9 MDC period and idle release
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk("R9 period", 32'(int'((t1 - t0) / 20.0)), 32'(2 * DIV_HALF));
    chk("R9 idle oe", {31'b0, mdio_oe}, 32'h0);

    // table of commands
    for (int v = 0; v < 6; v++) begin
      vec_t c;
      c = VECS[v];
      n0 = nf;
      wr(4'h8, {16'h0, c.ra});
      wr(4'h0, mk(c.op, c.prt, c.dev, c.wd));
      rd(4'h0, d); chk("R2 busy set", {31'b0, d[30]}, 32'h1);
      wait_idle(d);
      chk("R2 two frames", 32'(nf - n0), 32'd2);
      chk("R3 pre", {31'b0, f_pre[n0 % 64] >= 32}, 32'h1);
      chk("R3 st/op/ta", {26'b0, f_st[n0 % 64], f_op[n0 % 64], f_ta[n0 % 64]}, {26'b0, 2'b00, 2'b00, 2'b10});
      chk("R3 prt/dev", {22'b0, f_prt[n0 % 64], f_dev[n0 % 64]}, {22'b0, c.prt, c.dev});
      chk("R3 addr", {16'b0, f_dat[n0 % 64]}, {16'b0, c.ra});
      chk("R4 R5 prt/dev", {22'b0, f_prt[(n0 + 1) % 64], f_dev[(n0 + 1) % 64]}, {22'b0, c.prt, c.dev});
      if (c.op == 3'd5) begin
        chk("R4 op/ta", {28'b0, f_op[(n0 + 1) % 64], f_ta[(n0 + 1) % 64]}, {28'b0, 2'b01, 2'b10});
        chk("R4 data", {16'b0, f_dat[(n0 + 1) % 64]}, {16'b0, c.wd});
      end else begin
        chk("R5 op", {30'b0, f_op[(n0 + 1) % 64]}, {30'b0, 2'b11});
        chk("R5 valid", {31'b0, d[29]}, 32'h1);
        chk("R5 data", {16'b0, d[15:0]}, {16'b0, mdl(c.ra, c.prt, c.dev)});
      end
    end

    // R6 valid cleared by the next accepted command (last vector was a read)
    wr(4'h0, mk(3'd5, 5'd4, 5'd5, 16'h0F0F));
    rd(4'h0, d); chk("R6 valid clr", {30'b0, d[30:29]}, {30'b0, 2'b10});
    wait_idle(d);

    // R7 invalid operation codes
    n0 = nf;
    wr(4'h0, mk(3'd0, 5'd7, 5'd7, 16'h1111));
    rd(4'h0, d); chk("R7 op0 busy", {31'b0, d[30]}, 32'h0);
    wr(4'h0, mk(3'd6, 5'd7, 5'd7, 16'h2222));
    rd(4'h0, d); chk("R7 op6 busy", {31'b0, d[30]}, 32'h0);
    repeat (600) @(negedge clk);
    chk("R7 no frames", 32'(nf - n0), 32'd0);

    // R8 command while busy
    n0 = nf;
    wr(4'h8, 32'h0000_00AA);
    wr(4'h0, mk(3'd5, 5'd2, 5'd6, 16'hC3C3));
    wr(4'h0, mk(3'd7, 5'd9, 5'd9, 16'h0000));
    wait_idle(d);
    repeat (40) @(negedge clk);
    chk("R8 frames", 32'(nf - n0), 32'd2);
    chk("R8 op", {30'b0, f_op[(n0 + 1) % 64]}, {30'b0, 2'b01});
    chk("R8 data", {16'b0, f_dat[(n0 + 1) % 64]}, 32'h0000_C3C3);
    chk("R8 port field", {27'b0, d[20:16]}, 32'd2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule